// File: doc/BRIEF.md
# Flash page programming controller

This block sequences in-system programming of one page of an on-chip flash array. The CPU first fills a one-page staging buffer with byte writes, each giving a byte offset and a data byte. It then launches the operation with a target page number. The controller erases the target page to all-ones and then commits the staged bytes into it. Each of these two phases lasts a programmable number of clock cycles, standing in for the cell physics. The array itself is a register memory with a combinational read port.

Every request is qualified by the code region the CPU is executing from.
- Code running from external memory may neither stage bytes nor launch; such a request is refused and flagged.
- A launch from boot ROM runs in the background while the CPU keeps executing.
- A launch from user flash halts the CPU for the whole operation. Interrupt requests are held back during that time and handed to the CPU as the halt ends.

An external reset, a hardware watchdog reset or a secondary watchdog reset aborts the operation at any time. Only the target page can be disturbed by such an abort.

Top module: `flash_page_prog`

## Requirements
- R1: A staging write (`ld_en`) whose `fetch_src` is 0 (user flash) or 1 (boot ROM), made while `busy` is low, stores `ld_data` at byte `ld_offset`. After a completed operation, the target page equals the staging buffer byte for byte. Bytes never written since the last reset or the last completed operation read 0xFF.
- R2: When `fetch_src` is 2 or 3 (external code), a `ld_en` or `go` request pulses `denied` high for exactly the next cycle. No operation starts, and neither the staging buffer nor the array changes.
- R3: An accepted `go` raises `busy` from the next cycle. Counting the edge that samples `go` as edge 0, `done` is high for one cycle after edge ERASE_CYC+PROG_CYC. `busy` falls one cycle after that.
- R4: A launch with `fetch_src` = 1 never raises `cpu_halt`.
- R5: A launch with `fetch_src` = 0 holds `cpu_halt` high from the cycle after `go` until the cycle before `done`. `cpu_halt` is low in the `done` cycle.
- R6: Outside a halt, `irq_out` follows `irq_in`. While `cpu_halt` is high, `irq_out` is zero and every request bit seen is collected. In the cycle the halt ends by completion, `irq_out` shows the collected bits, and they are cleared one cycle later.
- R7: Any of `rst`, `wdt_rst` or `wdt2_rst` returns the controller to idle on the next cycle, with `busy` and `cpu_halt` low. It also discards collected interrupts and refills the staging buffer with 0xFF.
- R8: A reset during an operation leaves every page other than the target unchanged. Each target byte holds either its old value or 0xFF.
- R9: A `go` or `ld_en` from user flash or boot ROM that arrives while `busy` is high has no effect and pulses `busy_err` for the next cycle.
- R10: After each completed operation the staging buffer is all 0xFF. A second operation with no new staging writes therefore programs an all-0xFF page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External reset, synchronous, active high |
| wdt_rst | input | 1 | Hardware watchdog reset, synchronous, active high |
| wdt2_rst | input | 1 | Secondary watchdog reset, synchronous, active high |
| fetch_src | input | 2 | Code region in execution: 0 user flash, 1 boot ROM, 2 or 3 external |
| ld_en | input | 1 | Staging-buffer write strobe |
| ld_offset | input | OFS_W (7) | Byte offset within the page |
| ld_data | input | DATA_W (8) | Byte to stage |
| go | input | 1 | Launch strobe |
| go_page | input | PAGE_W (2) | Target page of the launch |
| rd_page | input | PAGE_W (2) | Array read page |
| rd_offset | input | OFS_W (7) | Array read byte offset |
| rd_data | output | DATA_W (8) | Array read data, combinational |
| irq_in | input | IRQ_W (4) | Interrupt requests from peripherals |
| irq_out | output | IRQ_W (4) | Interrupt requests presented to the CPU |
| busy | output | 1 | Operation in progress |
| cpu_halt | output | 1 | CPU execution halted (pseudo-idle) |
| done | output | 1 | One-cycle completion pulse |
| denied | output | 1 | One-cycle pulse: request refused for external code |
| busy_err | output | 1 | One-cycle pulse: request refused while busy |

## Verification
The bench reads array and flag outputs one time unit after a clock edge. `denied` and `busy_err` are due one edge after the request. `busy` is due one edge after `go`, and `done` exactly ERASE_CYC+PROG_CYC edges after it. The bench counts edges from the launch and compares that count against this figure. `cpu_halt` is sampled in the middle of each phase. Released interrupts are expected in the `done` cycle, and zero on the cycle after. Array reads are combinational, so page contents are compared only while `busy` is low, against a bench model fed by the accepted requests.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [1:0] {
        SRC_USER = 2'd0,
        SRC_BOOT = 2'd1,
        SRC_EXT0 = 2'd2,
        SRC_EXT1 = 2'd3
    } fetch_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_PROG  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic erase;
        logic commit;
    } arr_cmd_t;

    function automatic logic src_may_write(input logic [1:0] src);
        return !src[1];
    endfunction

    function automatic logic src_halts_cpu(input logic [1:0] src);
        return src == SRC_USER;
    endfunction
endpackage

// File: rtl/fpp_latch_buf.sv
module fpp_latch_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst_any,
    input  logic                               wr_en,
    input  logic [OFS_W-1:0]                   wr_ofs,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               clr,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  page_q
);
    always_ff @(posedge clk) begin
        if (rst_any || clr) begin
            page_q <= '1;
        end else if (wr_en) begin
            page_q[wr_ofs] <= wr_data;
        end
    end
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic                               clk,
    input  flash_pkg::arr_cmd_t                cmd,
    input  logic [PAGE_W-1:0]                  wr_page,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  wr_data,
    input  logic [PAGE_W-1:0]                  rd_page,
    input  logic [OFS_W-1:0]                   rd_ofs,
    output logic [DATA_W-1:0]                  rd_data
);
    logic [DATA_W-1:0] mem [NUM_PAGES][PAGE_BYTES];

    always_ff @(posedge clk) begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
            if (cmd.erase) begin
                mem[wr_page][b] <= '1;
            end else if (cmd.commit) begin
                mem[wr_page][b] <= wr_data[b];
            end
        end
    end

    assign rd_data = mem[rd_page][rd_ofs];
endmodule

// File: rtl/fpp_seq.sv
module fpp_seq #(
    parameter int ERASE_CYC = 6,
    parameter int PROG_CYC  = 10,
    parameter int PAGE_W    = 2,
    localparam int LONGEST  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CNT_W    = $clog2(LONGEST + 1)
) (
    input  logic                 clk,
    input  logic                 rst_any,
    input  logic                 start,
    input  logic                 start_halting,
    input  logic [PAGE_W-1:0]    start_page,
    output logic                 busy,
    output logic                 halt,
    output logic                 done,
    output flash_pkg::arr_cmd_t  arr_cmd,
    output logic [PAGE_W-1:0]    tgt_page,
    output logic                 latch_clr
);
    import flash_pkg::*;

    seq_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               halting_q;
    logic               last_erase;
    logic               last_prog;

    assign last_erase = (state_q == ST_ERASE) && (cnt_q == CNT_W'(ERASE_CYC - 1));
    assign last_prog  = (state_q == ST_PROG)  && (cnt_q == CNT_W'(PROG_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst_any) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            halting_q <= 1'b0;
            tgt_page  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_ERASE;
                        cnt_q     <= '0;
                        halting_q <= start_halting;
                        tgt_page  <= start_page;
                    end
                end
                ST_ERASE: begin
                    if (last_erase) begin
                        state_q <= ST_PROG;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (last_prog) begin
                        state_q <= ST_DONE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q   <= ST_IDLE;
                    halting_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign done           = (state_q == ST_DONE);
    assign halt           = halting_q && (state_q == ST_ERASE || state_q == ST_PROG);
    assign arr_cmd.erase  = last_erase && !rst_any;
    assign arr_cmd.commit = last_prog && !rst_any;
    assign latch_clr      = last_prog && !rst_any;
endmodule

// File: rtl/fpp_irq_hold.sv
module fpp_irq_hold #(
    parameter int IRQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              halt,
    input  logic [IRQ_W-1:0]  irq_in,
    output logic [IRQ_W-1:0]  irq_out
);
    logic [IRQ_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            held_q <= '0;
        end else if (halt) begin
            held_q <= held_q | irq_in;
        end else begin
            held_q <= '0;
        end
    end

    assign irq_out = halt ? '0 : (irq_in | held_q);
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int IRQ_W      = 4,
    parameter int ERASE_CYC  = 6,
    parameter int PROG_CYC   = 10,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wdt_rst,
    input  logic               wdt2_rst,
    input  logic [1:0]         fetch_src,
    input  logic               ld_en,
    input  logic [OFS_W-1:0]   ld_offset,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic               go,
    input  logic [PAGE_W-1:0]  go_page,
    input  logic [PAGE_W-1:0]  rd_page,
    input  logic [OFS_W-1:0]   rd_offset,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [IRQ_W-1:0]   irq_in,
    output logic [IRQ_W-1:0]   irq_out,
    output logic               busy,
    output logic               cpu_halt,
    output logic               done,
    output logic               denied,
    output logic               busy_err
);
    import flash_pkg::*;

    logic                              rst_any;
    logic                              src_ok;
    logic                              start_ok;
    logic                              load_ok;
    logic                              latch_clr;
    logic [PAGE_W-1:0]                 tgt_page;
    arr_cmd_t                          arr_cmd;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] latch_page;

    assign rst_any  = rst || wdt_rst || wdt2_rst;
    assign src_ok   = src_may_write(fetch_src);
    assign start_ok = go && src_ok && !busy;
    assign load_ok  = ld_en && src_ok && !busy;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            denied   <= 1'b0;
            busy_err <= 1'b0;
        end else begin
            denied   <= (go || ld_en) && !src_ok;
            busy_err <= (go || ld_en) && src_ok && busy;
        end
    end

    fpp_seq #(
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .PAGE_W    (PAGE_W)
    ) u_seq (
        .clk           (clk),
        .rst_any       (rst_any),
        .start         (start_ok),
        .start_halting (src_halts_cpu(fetch_src)),
        .start_page    (go_page),
        .busy          (busy),
        .halt          (cpu_halt),
        .done          (done),
        .arr_cmd       (arr_cmd),
        .tgt_page      (tgt_page),
        .latch_clr     (latch_clr)
    );

    fpp_latch_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_any (rst_any),
        .wr_en   (load_ok),
        .wr_ofs  (ld_offset),
        .wr_data (ld_data),
        .clr     (latch_clr),
        .page_q  (latch_page)
    );

    fpp_array #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_array (
        .clk     (clk),
        .cmd     (arr_cmd),
        .wr_page (tgt_page),
        .wr_data (latch_page),
        .rd_page (rd_page),
        .rd_ofs  (rd_offset),
        .rd_data (rd_data)
    );

    fpp_irq_hold #(
        .IRQ_W (IRQ_W)
    ) u_irq (
        .clk     (clk),
        .rst_any (rst_any),
        .halt    (cpu_halt),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int IRQ_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wdt_rst,
    input logic             wdt2_rst,
    input logic [1:0]       fetch_src,
    input logic             go,
    input logic             ld_en,
    input logic             busy,
    input logic             cpu_halt,
    input logic             done,
    input logic             denied,
    input logic             busy_err,
    input logic [IRQ_W-1:0] irq_out
);
    assert_ext_denied_R2: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        ((go || ld_en) && fetch_src[1] && !busy) |=> (denied && !busy));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        done |=> (!done && !busy));

    assert_boot_no_halt_R4: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        (go && fetch_src == 2'd1 && !busy) |=> (busy && !cpu_halt));

    assert_user_halts_R5: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        (go && fetch_src == 2'd0 && !busy) |=> (busy && cpu_halt));

    assert_halt_in_op_R5: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        cpu_halt |-> busy);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        cpu_halt |-> (irq_out == '0));

    assert_wdt_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst || wdt2_rst) |=> (!busy && !cpu_halt));

    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (rst || wdt_rst || wdt2_rst)
        ((go || ld_en) && !fetch_src[1] && busy) |=> busy_err);
endmodule

bind flash_page_prog fpp_checker #(.IRQ_W(IRQ_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wdt_rst   (wdt_rst),
    .wdt2_rst  (wdt2_rst),
    .fetch_src (fetch_src),
    .go        (go),
    .ld_en     (ld_en),
    .busy      (busy),
    .cpu_halt  (cpu_halt),
    .done      (done),
    .denied    (denied),
    .busy_err  (busy_err),
    .irq_out   (irq_out)
);

// File: tb/tb_flash_page_prog.sv
module tb_flash_page_prog;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PAGES  = 4;
    localparam int PAGE_BYTES = 128;
    localparam int DATA_W     = 8;
    localparam int IRQ_W      = 4;
    localparam int ERASE_CYC  = 6;
    localparam int PROG_CYC   = 10;
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    localparam int PAGE_W     = $clog2(NUM_PAGES);

    logic clk = 1'b0;
    logic rst = 1'b1, wdt_rst = 1'b0, wdt2_rst = 1'b0;
    logic [1:0] fetch_src = 2'd1;
    logic ld_en = 1'b0;
    logic [OFS_W-1:0] ld_offset = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic go = 1'b0;
    logic [PAGE_W-1:0] go_page = '0;
    logic [PAGE_W-1:0] rd_page = '0;
    logic [OFS_W-1:0] rd_offset = '0;
    logic [DATA_W-1:0] rd_data;
    logic [IRQ_W-1:0] irq_in = '0;
    logic [IRQ_W-1:0] irq_out;
    logic busy, cpu_halt, done, denied, busy_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_mem [NUM_PAGES][PAGE_BYTES];
    logic [DATA_W-1:0] lat [PAGE_BYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_page_prog #(
        .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W),
        .IRQ_W(IRQ_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
    ) dut (
        .clk(clk), .rst(rst), .wdt_rst(wdt_rst), .wdt2_rst(wdt2_rst),
        .fetch_src(fetch_src), .ld_en(ld_en), .ld_offset(ld_offset), .ld_data(ld_data),
        .go(go), .go_page(go_page), .rd_page(rd_page), .rd_offset(rd_offset),
        .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out), .busy(busy),
        .cpu_halt(cpu_halt), .done(done), .denied(denied), .busy_err(busy_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [DATA_W-1:0] ff_byte();
        return '1;
    endfunction

    task automatic clear_latch_model();
        for (int i = 0; i < PAGE_BYTES; i++) lat[i] = ff_byte();
    endtask

    task automatic read_byte(input int p, input int o, output logic [DATA_W-1:0] v);
        rd_page = PAGE_W'(p);
        rd_offset = OFS_W'(o);
        #1;
        v = rd_data;
    endtask

    task automatic check_page(input int p, input string req);
        logic [DATA_W-1:0] v;
        int bad_ofs = -1;
        int act = 0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            read_byte(p, i, v);
            if (v !== exp_mem[p][i] && bad_ofs < 0) begin
                bad_ofs = i;
                act = int'(v);
            end
        end
        if (bad_ofs < 0) chk(1'b1, req, "page", 0, 0);
        else chk(1'b0, req, $sformatf("page %0d byte %0d", p, bad_ofs),
                 act, int'(exp_mem[p][bad_ofs]));
    endtask

    task automatic load(input int src, input int o, input int d);
        fetch_src = 2'(src);
        ld_en = 1'b1;
        ld_offset = OFS_W'(o);
        ld_data = DATA_W'(d);
        tick();
        ld_en = 1'b0;
        if (src < 2 && !busy) lat[o] = DATA_W'(d);
    endtask

    task automatic launch(input int src, input int p);
        fetch_src = 2'(src);
        go = 1'b1;
        go_page = PAGE_W'(p);
        tick();
        go = 1'b0;
    endtask

    task automatic run_op(input int src, input int p, input bit feed_irq, input string req);
        int n = 0;
        logic [IRQ_W-1:0] held = '0;
        launch(src, p);
        chk(busy == 1'b1, "R3", "busy after go", int'(busy), 1);
        while (!done && n < 1000) begin
            if (n == ERASE_CYC / 2 || n == ERASE_CYC + PROG_CYC / 2) begin
                chk(cpu_halt == (src == 0), (src == 0) ? "R5" : "R4", "halt mid-op",
                    int'(cpu_halt), int'(src == 0));
            end
            if (feed_irq && n < ERASE_CYC + PROG_CYC - 1) begin
                irq_in = IRQ_W'($urandom);
                #1;
                chk(irq_out == '0, "R6", "irq masked", int'(irq_out), 0);
                held = held | irq_in;
            end
            tick();
            irq_in = '0;
            n++;
        end
        chk(n == ERASE_CYC + PROG_CYC, "R3", "edges to done", n, ERASE_CYC + PROG_CYC);
        chk(cpu_halt == 1'b0, "R5", "halt low in done", int'(cpu_halt), 0);
        if (feed_irq) begin
            #1;
            chk(irq_out == held, "R6", "released irq", int'(irq_out), int'(held));
        end
        for (int i = 0; i < PAGE_BYTES; i++) exp_mem[p][i] = lat[i];
        clear_latch_model();
        tick();
        chk(done == 1'b0 && busy == 1'b0, "R3", "done one cycle then idle",
            int'({done, busy}), 0);
        if (feed_irq) chk(irq_out == '0, "R6", "held irq cleared", int'(irq_out), 0);
        check_page(p, req);
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        void'($urandom(32'h5eed_1234));
        clear_latch_model();
        tick();
        tick();
        rst = 1'b0;
        chk({busy, cpu_halt, done, denied, busy_err} == 5'b0, "R7", "reset outputs",
            int'({busy, cpu_halt, done, denied, busy_err}), 0);
        for (int p = 0; p < NUM_PAGES; p++)
            for (int i = 0; i < PAGE_BYTES; i++) begin
                read_byte(p, i, v);
                exp_mem[p][i] = v;
            end

        // R1: boundary offsets, boot ROM launch (R4: no halt)
        load(1, 0, 8'h12);
        load(1, PAGE_BYTES - 1, 8'h34);
        load(0, 5, 8'h00);
        run_op(1, 0, 1'b0, "R1");

        // R10: no staging writes -> all 0xFF
        run_op(1, 1, 1'b0, "R10");

        // R5 / R6: user flash launch with interrupts during pseudo-idle
        for (int i = 0; i < 20; i++) load(0, int'($urandom % PAGE_BYTES), int'($urandom));
        run_op(0, 1, 1'b1, "R1");

        // R6: pass-through outside halt
        irq_in = 4'b1010;
        #1;
        chk(irq_out == 4'b1010, "R6", "irq pass-through", int'(irq_out), 10);
        irq_in = '0;

        // R2: external code loads and launches denied
        for (int s = 2; s < 4; s++) begin
            load(s, 3, 8'h55);
            chk(denied == 1'b1, "R2", "denied on load", int'(denied), 1);
            launch(s, 2);
            chk(denied == 1'b1 && busy == 1'b0, "R2", "denied on go", int'({denied, busy}), 2);
            tick();
            chk(denied == 1'b0, "R2", "denied one cycle", int'(denied), 0);
        end
        run_op(1, 2, 1'b0, "R2");

        // Random programs
        for (int r = 0; r < 4; r++) begin
            int pg = int'($urandom % NUM_PAGES);
            int src = int'($urandom % 2);
            for (int i = 0; i < 24; i++) load(int'($urandom % 2), int'($urandom % PAGE_BYTES), int'($urandom));
            run_op(src, pg, src == 0, "R1");
        end

        // R9: requests while busy
        load(1, 7, 8'hA5);
        launch(1, 3);
        tick();
        launch(0, 2);
        chk(busy_err == 1'b1, "R9", "busy_err on go", int'(busy_err), 1);
        load(1, 8, 8'h5A);
        chk(busy_err == 1'b1, "R9", "busy_err on load", int'(busy_err), 1);
        while (!done) tick();
        for (int i = 0; i < PAGE_BYTES; i++) exp_mem[3][i] = lat[i];
        clear_latch_model();
        tick();
        check_page(3, "R9");
        check_page(2, "R9");

        // R7 / R8: watchdog reset during PROGRAM phase
        for (int i = 0; i < 10; i++) load(0, i, 8'h3C);
        launch(0, 2);
        repeat (ERASE_CYC + 2) begin
            irq_in = 4'b0110;
            tick();
        end
        irq_in = '0;
        wdt_rst = 1'b1;
        tick();
        wdt_rst = 1'b0;
        clear_latch_model();
        chk(busy == 1'b0 && cpu_halt == 1'b0, "R7", "abort by watchdog", int'({busy, cpu_halt}), 0);
        #1;
        chk(irq_out == '0, "R7", "held irq discarded", int'(irq_out), 0);
        begin
            int bad = 0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                read_byte(2, i, v);
                if (v !== exp_mem[2][i] && v !== ff_byte()) bad++;
                exp_mem[2][i] = v;
            end
            chk(bad == 0, "R8", "target old or erased", bad, 0);
        end
        for (int p = 0; p < NUM_PAGES; p++) if (p != 2) check_page(p, "R8");

        // R8: secondary watchdog during ERASE leaves target unchanged
        load(1, 1, 8'h77);
        launch(1, 0);
        tick();
        wdt2_rst = 1'b1;
        tick();
        wdt2_rst = 1'b0;
        clear_latch_model();
        chk(busy == 1'b0, "R7", "abort by second watchdog", int'(busy), 0);
        for (int p = 0; p < NUM_PAGES; p++) check_page(p, "R8");

        // R7: latches refilled by reset
        run_op(1, 3, 1'b0, "R7");

        // R7: external reset mid-op
        launch(0, 1);
        repeat (3) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(busy == 1'b0 && cpu_halt == 1'b0, "R7", "abort by external reset", int'({busy, cpu_halt}), 0);
        for (int p = 0; p < NUM_PAGES; p++) check_page(p, "R8");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule